// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a watchdog built around a small up-counter that advances at a slow rate. A prescaler divides a slow-tick enable, and each time the prescaler completes one pass the counter steps by one. When the counter wraps from all ones back to zero, the block raises a one-cycle interrupt request. Software cannot mask this request.

After reset the counter is stopped. Software starts it, and afterwards keeps it from wrapping, by writing a two-value key into a small write-only control register. A one-bit write pointer flips on every write to that register, whatever the data. The key is accepted only when the first value lands while the pointer is 0 and the second value lands on the very next write, while the pointer is 1. A wrap sends the pointer back to 0. An accepted key starts a stopped counter. On a running counter it returns the count to zero and also restarts the prescaler.

The widths, the prescale ratio and both key values are parameters. The defaults are a 9-bit counter, a divide-by-128 prescaler and the keys 5h then Ah. With a 32.768 kHz tick enable, these defaults give a 2 s wrap period. Software must clear the counter within that period less one counter step.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the counter is stopped and `wdt_irq` stays low, however many slow ticks arrive, until a valid key is accepted.
- R2: An accepted key starts a stopped counter, or returns a running counter to zero. The next wrap then comes a full period after the write that carried the second key value.
- R3: The write pointer toggles on every `wr_en` cycle, whatever the value of `wr_data`.
- R4: A key is accepted only when `wr_data` = 4'h5 is written at pointer 0 and 4'hA is written at pointer 1 on the next write. A stray write shifts the pointer, so any other ordering is rejected.
- R5: Every wrap forces the pointer back to 0 and discards a half-entered key.
- R6: Every wrap of the counter from all ones to zero gives a `wdt_irq` pulse exactly one clock wide. The pulse is high in the cycle after the clock edge on which the wrap happens, and nothing can mask it.
- R7: The counter advances once every PRESC_DIV slow ticks. The wrap period is therefore PRESC_DIV × 2^CNT_W slow ticks.
- R8: An accepted key also resets the prescaler, so the first increment after a clear comes a full PRESC_DIV ticks later.
- R9: Once started, the counter keeps running through every wrap. Only reset stops it.
- R10: If a key is accepted on the same clock edge on which the counter would wrap, the clear wins and no `wdt_irq` pulse occurs.
- R11: Clock cycles with `slow_tick` low do not advance the prescaler or the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_tick | input | 1 | One-cycle enable from the slow clock domain |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | KEY_W | Value written to the control register |
| wdt_irq | output | 1 | Non-maskable interrupt pulse on each counter wrap |

## Verification
The bound checker holds on every cycle that the interrupt is a single-cycle pulse, that it never appears while the counter is stopped, and that the pointer sits at 0 whenever it does. It also checks that each write flips the pointer unless a wrap overrides it, and that an accepted key leaves a running counter at zero with no pulse after it. The directed scenarios show what only whole periods can reveal: the exact wrap period, the prescaler restart on a clear, and the rejection of keys that arrive out of order. They also show that a pointer left at 1 is cleared by a wrap, that a clear on the exact wrap edge wins, and that the period stretches when slow ticks are sparse.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   typedef struct packed {
      logic ptr;    // write pointer, toggles per write
      logic armed;  // first key value seen at pointer 0
   } kwd_key_st_t;
endpackage

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
   parameter int DIV = 128
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic restart,
   input  logic tick,
   output logic step
);
   initial begin
      if (DIV < 1) $error("kwd_prescale: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_bypass
         assign step = run && tick && !restart;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pcnt;

         assign step = run && tick && !restart && (pcnt == LAST);

         always_ff @(posedge clk) begin
            if (rst || restart || !run) begin
               pcnt <= '0;
            end else if (tick) begin
               pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
   import kwd_pkg::*;
#(
   parameter int            KEY_W   = 4,
   parameter logic [KEY_W-1:0] KEY_A = 4'h5,
   parameter logic [KEY_W-1:0] KEY_B = 4'hA
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [KEY_W-1:0] wr_data,
   input  logic             ovf,
   output logic             key_ok,
   output logic             ptr
);
   kwd_key_st_t st;

   assign ptr    = st.ptr;
   assign key_ok = wr_en && st.ptr && st.armed && (wr_data == KEY_B);

   always_ff @(posedge clk) begin
      if (rst || ovf) begin
         st <= '0;
      end else if (wr_en) begin
         st.ptr   <= ~st.ptr;
         st.armed <= !st.ptr && (wr_data == KEY_A);
      end
   end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             key_ok,
   input  logic             step,
   output logic             running,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf,
   output logic             irq
);
   assign ovf = running && step && (&cnt) && !key_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         running <= 1'b0;
         cnt     <= '0;
         irq     <= 1'b0;
      end else begin
         irq <= ovf;
         if (key_ok) begin
            running <= 1'b1;
            cnt     <= '0;
         end else if (running && step) begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
   parameter int               CNT_W     = 9,
   parameter int               PRESC_DIV = 128,
   parameter int               KEY_W     = 4,
   parameter logic [KEY_W-1:0] KEY_A     = 4'h5,
   parameter logic [KEY_W-1:0] KEY_B     = 4'hA
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             slow_tick,
   input  logic             wr_en,
   input  logic [KEY_W-1:0] wr_data,
   output logic             wdt_irq
);
   initial begin
      if (CNT_W < 2) $error("keyed_watchdog: CNT_W must be at least 2");
      if (KEY_A == KEY_B) $error("keyed_watchdog: key values must differ");
   end

   logic             key_ok;
   logic             ptr;
   logic             step;
   logic             running;
   logic             ovf;
   logic [CNT_W-1:0] cnt;

   kwd_keyseq #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_keys (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .ovf(ovf), .key_ok(key_ok), .ptr(ptr)
   );

   kwd_prescale #(.DIV(PRESC_DIV)) u_presc (
      .clk(clk), .rst(rst), .run(running), .restart(key_ok),
      .tick(slow_tick), .step(step)
   );

   kwd_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .key_ok(key_ok), .step(step),
      .running(running), .cnt(cnt), .ovf(ovf), .irq(wdt_irq)
   );
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic             wdt_irq,
   input logic             ptr,
   input logic             key_ok,
   input logic             running,
   input logic             step,
   input logic [CNT_W-1:0] cnt
);
   // R1: no pulse while stopped
   a_r1_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
      !running |-> !wdt_irq);
   // R6: pulse is one cycle wide
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
      wdt_irq |=> !wdt_irq);
   // R5: pointer is back at 0 when the pulse shows
   a_r5_ptr_reset_on_wrap: assert property (@(posedge clk) disable iff (rst)
      wdt_irq |-> !ptr);
   // R3: each write flips the pointer unless a wrap overrides it
   a_r3_ptr_toggles: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (ptr != $past(ptr)) || wdt_irq);
   // R2: accepted key leaves the counter running at zero
   a_r2_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
      key_ok |=> running && (cnt == '0));
   // R10: clear wins over a same-edge wrap
   a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
      key_ok |=> !wdt_irq);
   // R11: no advance without a prescaler step
   a_r11_hold_without_step: assert property (@(posedge clk) disable iff (rst)
      !step && !key_ok |=> $stable(cnt));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wdt_irq(wdt_irq), .ptr(ptr),
   .key_ok(key_ok), .running(running), .step(step), .cnt(cnt)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
   localparam int CNT_W  = 4;
   localparam int DIV    = 4;
   localparam int PERIOD = DIV * (1 << CNT_W);  // 64 cycles at full tick rate

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       slow_tick = 1'b1;
   logic       wr_en = 1'b0;
   logic [3:0] wr_data = 4'h0;
   logic       wdt_irq;
   logic       half_rate = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   keyed_watchdog #(.CNT_W(CNT_W), .PRESC_DIV(DIV)) uut (
      .clk(clk), .rst(rst), .slow_tick(slow_tick),
      .wr_en(wr_en), .wr_data(wr_data), .wdt_irq(wdt_irq)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      if (half_rate) slow_tick = ~slow_tick;
      else           slow_tick = 1'b1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; wr_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic write(input logic [3:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(posedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic key();
      write(4'h5); write(4'hA);
   endtask

   // count rising edges until a pulse is seen; returns 0 if none within limit
   task automatic measure(input int limit, output int n);
      n = 0;
      for (int i = 1; i <= limit; i++) begin
         @(posedge clk); #2;
         if (wdt_irq) begin n = i; break; end
      end
   endtask

   task automatic t_reset_idle();
      int n;
      do_reset();
      #2 check(wdt_irq == 1'b0, "R1 reset value", wdt_irq, 0);
      measure(4 * PERIOD, n);
      check(n == 0, "R1 stopped without key", n, 0);
   endtask

   task automatic t_start_and_run();
      int n;
      do_reset();
      key();
      measure(3 * PERIOD, n);
      check(n == PERIOD, "R2 R7 first wrap period", n, PERIOD);
      @(posedge clk); #2;
      check(wdt_irq == 1'b0, "R6 pulse one cycle", wdt_irq, 0);
      measure(3 * PERIOD, n);
      check(n == PERIOD - 1, "R9 keeps running after wrap", n, PERIOD - 1);
   endtask

   task automatic t_clear_mid();
      int n;
      do_reset();
      key();
      repeat (41) @(posedge clk);
      key();
      measure(3 * PERIOD, n);
      check(n == PERIOD, "R8 clear restarts prescaler and count", n, PERIOD);
   endtask

   task automatic t_bad_order();
      int n;
      do_reset();
      write(4'h7); write(4'h5); write(4'hA);  // pointer misaligned
      write(4'h5); write(4'hA);               // 5 at ptr1, A at ptr0
      measure(3 * PERIOD, n);
      check(n == 0, "R4 misaligned keys rejected", n, 0);
      write(4'hA); write(4'h5);               // swapped order
      measure(2 * PERIOD, n);
      check(n == 0, "R4 swapped order rejected", n, 0);
      write(4'h3);                            // realign pointer to 0
      key();
      measure(3 * PERIOD, n);
      check(n == PERIOD, "R3 pointer toggles on any data", n, PERIOD);
   endtask

   task automatic t_wrap_resets_ptr();
      int n;
      do_reset();
      key();
      measure(3 * PERIOD, n);
      repeat (20) @(posedge clk);
      write(4'h5);                            // leaves pointer at 1
      measure(3 * PERIOD, n);
      check(n > 0, "R6 unmaskable wrap pulse", n, 1);
      key();
      measure(3 * PERIOD, n);
      check(n == PERIOD, "R5 wrap returns pointer to 0", n, PERIOD);
   endtask

   task automatic t_clear_on_wrap();
      int n;
      do_reset();
      key();                                  // counting starts from edge E0
      repeat (62) @(posedge clk);
      write(4'h5);                            // sampled at E63
      write(4'hA);                            // sampled at E64, the wrap edge
      #2 check(wdt_irq == 1'b0, "R10 clear beats wrap", wdt_irq, 0);
      measure(3 * PERIOD, n);
      check(n == PERIOD, "R10 period after same-edge clear", n, PERIOD);
   endtask

   task automatic t_sparse_ticks();
      int n;
      do_reset();
      half_rate = 1'b1;
      key();
      measure(4 * PERIOD, n);
      check(n >= 2 * PERIOD - 1 && n <= 2 * PERIOD + 1,
            "R11 idle tick cycles do not advance", n, 2 * PERIOD);
      half_rate = 1'b0;
   endtask

   initial begin
      t_reset_idle();
      t_start_and_run();
      t_clear_mid();
      t_bad_order();
      t_wrap_resets_ptr();
      t_clear_on_wrap();
      t_sparse_ticks();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            check(1'b0, "watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule